// File: doc/BRIEF.md
# Virtual Interrupt End-of-Interrupt Deactivation Unit

This unit completes an end-of-interrupt write on a virtualised interrupt controller CPU interface. It captures the written interrupt ID together with the caller's current group, the end-of-interrupt mode bit and the number of preemption bits. It always asks an external active-priority tracker to drop the highest active priority, and it samples the priority value that the tracker reports back.

Unless the ID lies in the message-signalled range or the mode bit splits priority drop from deactivation, the unit searches a small bank of list registers. It looks for the lowest-indexed entry in use that is active and carries the written virtual ID. A match whose group and preemption-scaled priority agree with the request loses its active bit. If that entry is linked to a physical interrupt, the unit also strobes a physical deactivate request. When nothing matches, a 5-bit miss counter advances.

The bank is loaded and inspected through a simple write port and a combinational read port. Each request runs through a two-stage scan-and-compare pipeline. The unit then signals completion with a one-cycle done pulse.

Top module: `eoi_deact_unit`

## Requirements
- R1: During and right after reset, drop_req, done and deact_req are 0, eoi_count is 0 and every list-register entry reads back as all zeros.
- R2: An EOI accepted at clock edge k raises drop_req for exactly the one cycle between edges k and k+1, whatever the ID, mode or bank contents; drop_prio is sampled at edge k+1.
- R3: For an EOI accepted at edge k, done is high for exactly the cycle after edge k+2. All list-register, counter and deactivate effects also appear at edge k+2.
- R4: A written ID of 8192 or more causes no list-register change, no deactivate strobe and no counter change.
- R5: With eoi_mode = 1 the list registers, the counter and the deactivate strobe are untouched; only the priority drop occurs.
- R6: Entry bit layout is vid [36:21], pid [20:11], priority [10:3], group [2], hw-linked [1], active [0]. The search considers only indices below lr_used and picks the lowest index whose active bit is 1 and whose vid equals the written ID.
- R7: When the search finds no entry, eoi_count increases by one modulo 32; it changes in no other case.
- R8: If the found entry's group bit differs from eoi_grp, nothing besides the priority drop happens.
- R9: Priorities are compared after keeping only their top pre_bits bits. Both the entry priority and drop_prio are masked this way, and on a mismatch nothing besides the priority drop happens.
- R10: On a valid match only the active bit of the found entry is cleared; all its other fields and all other entries keep their values.
- R11: A valid match on an entry with the hw-linked bit set drives deact_req for one cycle, together with done, with deact_pid equal to the entry's pid; otherwise deact_req stays 0.
- R12: eoi_valid is ignored while a request is in flight (from its acceptance edge until the edge that raises done). Such a write produces no extra priority drop or done.
- R13: A bank write and a deactivation clear may land on the same edge. On different entries both take effect; on the same entry the written data wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoi_valid | input | 1 | EOI write request |
| eoi_id | input | 16 | Written virtual interrupt ID |
| eoi_grp | input | 1 | Current interrupt group |
| eoi_mode | input | 1 | 1: priority drop only |
| pre_bits | input | 4 | Number of preemption bits (1..8) |
| drop_req | output | 1 | Priority-drop request to the tracker |
| drop_prio | input | 8 | Priority dropped by the tracker |
| lr_used | input | 3 | Number of list registers in use |
| lr_wr_en | input | 1 | Bank write enable |
| lr_wr_idx | input | 2 | Bank write index |
| lr_wr_data | input | 37 | Bank write data |
| lr_rd_idx | input | 2 | Bank read index |
| lr_rd_data | output | 37 | Bank read data |
| deact_req | output | 1 | Physical deactivate strobe |
| deact_pid | output | 10 | Physical ID for the strobe |
| eoi_count | output | 5 | EOI miss counter |
| done | output | 1 | Request complete pulse |

## Verification
The clear of a found entry's active bit and an external bank write can land on the same clock edge. The bench provokes this by timing a write onto the edge that completes the EOI, first aimed at a different entry and then at the matched entry itself. After each case, all entries are read back through the read port and compared with a model. That model applies the clear first and then the write, so that the written data wins on a shared entry.

// File: rtl/eoi_pkg.sv
package eoi_pkg;
  localparam int VID_W  = 16;
  localparam int PID_W  = 10;
  localparam int PRIO_W = 8;

  typedef struct packed {
    logic [VID_W-1:0]  vid;
    logic [PID_W-1:0]  pid;
    logic [PRIO_W-1:0] prio;
    logic              grp;
    logic              hw;
    logic              active;
  } lr_t;

  localparam int LR_W = $bits(lr_t);

  // keep the top n bits of a priority
  function automatic logic [PRIO_W-1:0] pri_to_pre(input logic [PRIO_W-1:0] p,
                                                   input logic [3:0] n);
    return p & ~({PRIO_W{1'b1}} >> n);
  endfunction
endpackage

// File: rtl/eoi_lr_bank.sv
module eoi_lr_bank import eoi_pkg::*; #(
  parameter int NUM_LR = 4,
  localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  lr_t                    wr_data,
  input  logic                   clr_en,
  input  logic [IDX_W-1:0]       clr_idx,
  output lr_t [NUM_LR-1:0]       ents
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ents <= '0;
    end else begin
      for (int i = 0; i < NUM_LR; i++) begin
        if (wr_en && wr_idx == IDX_W'(i))
          ents[i] <= wr_data;
        else if (clr_en && clr_idx == IDX_W'(i))
          ents[i].active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eoi_lr_scan.sv
module eoi_lr_scan import eoi_pkg::*; #(
  parameter int NUM_LR = 4,
  localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
  localparam int UW    = $clog2(NUM_LR + 1)
) (
  input  lr_t [NUM_LR-1:0]  ents,
  input  logic [VID_W-1:0]  id,
  input  logic [UW-1:0]     used,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [PRIO_W-1:0] prio,
  output logic [PID_W-1:0]  pid,
  output logic              grp,
  output logic              hw
);
  logic [NUM_LR-1:0] match;

  for (genvar g = 0; g < NUM_LR; g++) begin : g_match
    assign match[g] = ents[g].active && (ents[g].vid == id) && (UW'(g) < used);
  end

  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = NUM_LR - 1; i >= 0; i--)
      if (match[i]) idx = IDX_W'(i);
    prio = ents[idx].prio;
    pid  = ents[idx].pid;
    grp  = ents[idx].grp;
    hw   = ents[idx].hw;
  end
endmodule

// File: rtl/eoi_miss_counter.sv
module eoi_miss_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (inc) q <= q + CNT_W'(1);
  end
endmodule

// File: rtl/eoi_deact_unit.sv
module eoi_deact_unit import eoi_pkg::*; #(
  parameter int NUM_LR   = 4,
  parameter int LPI_BASE = 8192,
  parameter int CNT_W    = 5,
  localparam int IDX_W   = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
  localparam int UW      = $clog2(NUM_LR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eoi_valid,
  input  logic [VID_W-1:0]  eoi_id,
  input  logic              eoi_grp,
  input  logic              eoi_mode,
  input  logic [3:0]        pre_bits,
  output logic              drop_req,
  input  logic [PRIO_W-1:0] drop_prio,
  input  logic [UW-1:0]     lr_used,
  input  logic              lr_wr_en,
  input  logic [IDX_W-1:0]  lr_wr_idx,
  input  logic [LR_W-1:0]   lr_wr_data,
  input  logic [IDX_W-1:0]  lr_rd_idx,
  output logic [LR_W-1:0]   lr_rd_data,
  output logic              deact_req,
  output logic [PID_W-1:0]  deact_pid,
  output logic [CNT_W-1:0]  eoi_count,
  output logic              done
);
  // stage 1: captured request, scan runs on it
  logic              s1_valid;
  logic [VID_W-1:0]  s1_id;
  logic              s1_grp;
  logic              s1_mode;
  logic [3:0]        s1_pre;
  // stage 2: scan result and dropped priority
  logic              s2_valid;
  logic              s2_skip;
  logic              s2_hit;
  logic [IDX_W-1:0]  s2_idx;
  logic [PRIO_W-1:0] s2_prio;
  logic [PRIO_W-1:0] s2_drop;
  logic [PID_W-1:0]  s2_pid;
  logic              s2_egrp;
  logic              s2_hw;
  logic              s2_grp;
  logic [3:0]        s2_pre;

  lr_t [NUM_LR-1:0]  bank_ents;
  logic              scan_hit;
  logic [IDX_W-1:0]  scan_idx;
  logic [PRIO_W-1:0] scan_prio;
  logic [PID_W-1:0]  scan_pid;
  logic              scan_grp;
  logic              scan_hw;

  // named events for the checker
  logic eoi_accept;
  logic grp_ok;
  logic pre_ok;
  logic ev_deact;
  logic ev_miss;
  logic ev_ignore;

  assign eoi_accept = eoi_valid && !s1_valid && !s2_valid;
  assign drop_req   = s1_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_id    <= '0;
      s1_grp   <= 1'b0;
      s1_mode  <= 1'b0;
      s1_pre   <= '0;
    end else begin
      s1_valid <= eoi_accept;
      if (eoi_accept) begin
        s1_id   <= eoi_id;
        s1_grp  <= eoi_grp;
        s1_mode <= eoi_mode;
        s1_pre  <= pre_bits;
      end
    end
  end

  eoi_lr_scan #(.NUM_LR(NUM_LR)) u_scan (
    .ents (bank_ents),
    .id   (s1_id),
    .used (lr_used),
    .hit  (scan_hit),
    .idx  (scan_idx),
    .prio (scan_prio),
    .pid  (scan_pid),
    .grp  (scan_grp),
    .hw   (scan_hw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_skip  <= 1'b0;
      s2_hit   <= 1'b0;
      s2_idx   <= '0;
      s2_prio  <= '0;
      s2_drop  <= '0;
      s2_pid   <= '0;
      s2_egrp  <= 1'b0;
      s2_hw    <= 1'b0;
      s2_grp   <= 1'b0;
      s2_pre   <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_skip <= s1_mode || (s1_id >= VID_W'(LPI_BASE));
        s2_hit  <= scan_hit;
        s2_idx  <= scan_idx;
        s2_prio <= scan_prio;
        s2_drop <= drop_prio;
        s2_pid  <= scan_pid;
        s2_egrp <= scan_grp;
        s2_hw   <= scan_hw;
        s2_grp  <= s1_grp;
        s2_pre  <= s1_pre;
      end
    end
  end

  assign grp_ok    = (s2_egrp == s2_grp);
  assign pre_ok    = (pri_to_pre(s2_prio, s2_pre) == pri_to_pre(s2_drop, s2_pre));
  assign ev_deact  = s2_valid && !s2_skip && s2_hit && grp_ok && pre_ok;
  assign ev_miss   = s2_valid && !s2_skip && !s2_hit;
  assign ev_ignore = s2_valid && !s2_skip && s2_hit && !(grp_ok && pre_ok);

  eoi_lr_bank #(.NUM_LR(NUM_LR)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (lr_wr_en),
    .wr_idx  (lr_wr_idx),
    .wr_data (lr_t'(lr_wr_data)),
    .clr_en  (ev_deact),
    .clr_idx (s2_idx),
    .ents    (bank_ents)
  );

  assign lr_rd_data = bank_ents[lr_rd_idx];

  eoi_miss_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ev_miss),
    .q     (eoi_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      deact_req <= 1'b0;
      deact_pid <= '0;
    end else begin
      done      <= s2_valid;
      deact_req <= ev_deact && s2_hw;
      if (ev_deact && s2_hw) deact_pid <= s2_pid;
    end
  end
endmodule

// File: rtl/eoi_deact_checker.sv
module eoi_deact_checker #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             drop_req,
  input logic             done,
  input logic             deact_req,
  input logic [CNT_W-1:0] eoi_count,
  input logic             ev_deact,
  input logic             ev_miss,
  input logic             ev_ignore
);
  AST_DROP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_req |=> !drop_req); // R2
  AST_DONE_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(drop_req, 2)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DEACT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    deact_req |-> (done && $past(ev_deact))); // R11
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_count != $past(eoi_count)) |-> (done && eoi_count == CNT_W'($past(eoi_count) + 1'b1))); // R7
  AST_MISS_BUMPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (eoi_count == CNT_W'($past(eoi_count) + 1'b1))); // R7
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_deact, ev_miss, ev_ignore})); // R6
endmodule

bind eoi_deact_unit eoi_deact_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .drop_req  (drop_req),
  .done      (done),
  .deact_req (deact_req),
  .eoi_count (eoi_count),
  .ev_deact  (ev_deact),
  .ev_miss   (ev_miss),
  .ev_ignore (ev_ignore)
);

// File: tb/tb_eoi_deact_unit.sv
`timescale 1ns/1ps
module tb_eoi_deact_unit;
  localparam int NLR = 4;

  logic        clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        eoi_valid;
  logic [15:0] eoi_id;
  logic        eoi_grp;
  logic        eoi_mode;
  logic [3:0]  pre_bits;
  logic        drop_req;
  logic [7:0]  drop_prio;
  logic [2:0]  lr_used;
  logic        lr_wr_en;
  logic [1:0]  lr_wr_idx;
  logic [36:0] lr_wr_data;
  logic [1:0]  lr_rd_idx;
  logic [36:0] lr_rd_data;
  logic        deact_req;
  logic [9:0]  deact_pid;
  logic [4:0]  eoi_count;
  logic        done;

  eoi_deact_unit dut (
    .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_id(eoi_id),
    .eoi_grp(eoi_grp), .eoi_mode(eoi_mode), .pre_bits(pre_bits),
    .drop_req(drop_req), .drop_prio(drop_prio), .lr_used(lr_used),
    .lr_wr_en(lr_wr_en), .lr_wr_idx(lr_wr_idx), .lr_wr_data(lr_wr_data),
    .lr_rd_idx(lr_rd_idx), .lr_rd_data(lr_rd_data), .deact_req(deact_req),
    .deact_pid(deact_pid), .eoi_count(eoi_count), .done(done)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic       deact;
    logic [9:0] pid;
    logic [4:0] cnt;
    string      tag;
  } exp_t;

  exp_t        sb[$];
  logic [36:0] mir [NLR];
  logic [4:0]  mcnt;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [36:0] mk(input logic [15:0] vid, input logic [9:0] pid,
                                     input logic [7:0] prio, input logic grp,
                                     input logic hw, input logic act);
    return {vid, pid, prio, grp, hw, act};
  endfunction

  function automatic logic [7:0] top_mask(input int n);
    if (n <= 0) return 8'h00;
    if (n >= 8) return 8'hFF;
    return 8'hFF << (8 - n);
  endfunction

  // monitor: pops the scoreboard on each done pulse
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n) begin
      if (deact_req && !done) chk("R11", "deact without done", 64'(deact_req), 64'(0));
      if (done) begin
        if (sb.size() == 0) begin
          chk("R3", "unexpected done", 64'(1), 64'(0));
        end else begin
          e = sb.pop_front();
          chk(e.tag, "deact_req", 64'(deact_req), 64'(e.deact));
          if (e.deact) chk(e.tag, "deact_pid", 64'(deact_pid), 64'(e.pid));
          chk(e.tag, "eoi_count", 64'(eoi_count), 64'(e.cnt));
        end
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog actual=timeout expected=finish");
    finish_run();
  end

  task automatic verify_bank(input string tag);
    for (int i = 0; i < NLR; i++) begin
      @(negedge clk);
      lr_rd_idx = 2'(i);
      #1;
      chk(tag, $sformatf("lr[%0d]", i), 64'(lr_rd_data), 64'(mir[i]));
    end
  endtask

  task automatic write_lr(input int idx, input logic [36:0] data);
    @(negedge clk);
    lr_wr_en = 1'b1; lr_wr_idx = 2'(idx); lr_wr_data = data;
    @(negedge clk);
    lr_wr_en = 1'b0;
    mir[idx] = data;
  endtask

  // reference: compute the expected outcome, update the mirror
  task automatic model(input logic [15:0] id, input logic grp, input logic mode,
                       input int pre, input logic [7:0] dprio, input string tag,
                       input bit do_wr, input int widx, input logic [36:0] wdata);
    exp_t e;
    int hit = -1;
    logic [36:0] ent;
    e.deact = 1'b0; e.pid = '0; e.tag = tag;
    if (!(id >= 16'd8192 || mode)) begin
      for (int i = 0; i < int'(lr_used); i++)
        if (hit < 0 && mir[i][36:21] == id && mir[i][0]) hit = i;
      if (hit < 0) begin
        mcnt = mcnt + 5'd1;
      end else begin
        ent = mir[hit];
        if (ent[2] == grp && (ent[10:3] & top_mask(pre)) == (dprio & top_mask(pre))) begin
          mir[hit][0] = 1'b0;
          if (ent[1]) begin e.deact = 1'b1; e.pid = ent[20:11]; end
        end
      end
    end
    if (do_wr) mir[widx] = wdata;
    e.cnt = mcnt;
    sb.push_back(e);
  endtask

  task automatic eoi(input logic [15:0] id, input logic grp, input logic mode,
                     input int pre, input logic [7:0] dprio, input string tag,
                     input bit do_wr = 1'b0, input int widx = 0,
                     input logic [36:0] wdata = '0);
    model(id, grp, mode, pre, dprio, tag, do_wr, widx, wdata);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_id = id; eoi_grp = grp; eoi_mode = mode;
    pre_bits = 4'(pre); drop_prio = dprio;
    @(negedge clk);                       // after acceptance edge k
    eoi_valid = 1'b0;
    chk("R2", "drop_req high", 64'(drop_req), 64'(1));
    @(negedge clk);                       // after k+1
    chk("R2", "drop_req low", 64'(drop_req), 64'(0));
    if (do_wr) begin
      lr_wr_en = 1'b1; lr_wr_idx = 2'(widx); lr_wr_data = wdata;
    end
    @(negedge clk);                       // after k+2
    lr_wr_en = 1'b0;
    chk("R3", "done at k+2", 64'(done), 64'(1));
    @(negedge clk);
    chk("R3", "done pulse", 64'(done), 64'(0));
    chk(tag, "scoreboard drained", 64'(sb.size()), 64'(0));
    verify_bank(tag);
  endtask

  initial begin
    int ndrop;
    logic [4:0] start_cnt;
    rst_n = 1'b0; eoi_valid = 1'b0; eoi_id = '0; eoi_grp = 1'b0; eoi_mode = 1'b0;
    pre_bits = 4'd8; drop_prio = '0; lr_used = 3'd4; lr_wr_en = 1'b0;
    lr_wr_idx = '0; lr_wr_data = '0; lr_rd_idx = '0; mcnt = '0;
    for (int i = 0; i < NLR; i++) mir[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "drop_req in reset", 64'(drop_req), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done", 64'(done), 64'(0));
    chk("R1", "deact_req", 64'(deact_req), 64'(0));
    chk("R1", "eoi_count", 64'(eoi_count), 64'(0));
    verify_bank("R1");

    write_lr(0, mk(16'd100, 10'h155, 8'h40, 1'b1, 1'b1, 1'b1));
    write_lr(1, mk(16'd101, 10'h0AA, 8'h80, 1'b1, 1'b0, 1'b1));
    write_lr(2, mk(16'd200, 10'h011, 8'h20, 1'b0, 1'b0, 1'b1));
    write_lr(3, mk(16'd8192, 10'h003, 8'h10, 1'b1, 1'b1, 1'b1));

    eoi(16'd100, 1'b1, 1'b0, 8, 8'h40, "R11");   // hw-linked match
    eoi(16'd101, 1'b1, 1'b0, 8, 8'h80, "R10");   // plain match
    eoi(16'd100, 1'b1, 1'b0, 8, 8'h40, "R7");    // now inactive: miss
    eoi(16'd200, 1'b1, 1'b0, 8, 8'h20, "R8");    // group mismatch
    eoi(16'd200, 1'b0, 1'b1, 8, 8'h20, "R5");    // mode 1
    eoi(16'd8192, 1'b1, 1'b0, 8, 8'h10, "R4");   // message-signalled range

    write_lr(0, mk(16'd300, 10'h005, 8'h48, 1'b1, 1'b1, 1'b1));
    eoi(16'd300, 1'b1, 1'b0, 5, 8'h40, "R9");    // 0x48 vs 0x40 at 5 bits
    eoi(16'd300, 1'b1, 1'b0, 4, 8'h40, "R9");    // equal at 4 bits

    write_lr(0, mk(16'd400, 10'h001, 8'h30, 1'b1, 1'b1, 1'b0));
    write_lr(1, mk(16'd400, 10'h002, 8'h30, 1'b1, 1'b1, 1'b1));
    write_lr(2, mk(16'd400, 10'h003, 8'h30, 1'b1, 1'b1, 1'b1));
    eoi(16'd400, 1'b1, 1'b0, 8, 8'h30, "R6");    // lowest active: index 1
    eoi(16'd400, 1'b1, 1'b0, 8, 8'h30, "R6");    // then index 2
    eoi(16'd400, 1'b1, 1'b0, 8, 8'h30, "R6");    // then miss

    write_lr(3, mk(16'd500, 10'h007, 8'h50, 1'b1, 1'b1, 1'b1));
    lr_used = 3'd3;
    eoi(16'd500, 1'b1, 1'b0, 8, 8'h50, "R6");    // beyond lr_used: miss
    lr_used = 3'd4;
    eoi(16'd500, 1'b1, 1'b0, 8, 8'h50, "R6");

    // R12: hold eoi_valid across the busy window
    model(16'd999, 1'b1, 1'b0, 8, 8'h00, "R12", 1'b0, 0, '0);
    ndrop = 0;
    @(negedge clk);
    eoi_valid = 1'b1; eoi_id = 16'd999; eoi_grp = 1'b1; eoi_mode = 1'b0; pre_bits = 4'd8;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (drop_req) ndrop++;
    end
    eoi_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12", "drop_req cycles", 64'(ndrop), 64'(1));
    chk("R12", "scoreboard drained", 64'(sb.size()), 64'(0));
    chk("R12", "eoi_count", 64'(eoi_count), 64'(mcnt));

    // R13: bank write on the clearing edge
    write_lr(0, mk(16'd600, 10'h009, 8'h60, 1'b1, 1'b1, 1'b1));
    eoi(16'd600, 1'b1, 1'b0, 8, 8'h60, "R13", 1'b1, 1,
        mk(16'd601, 10'h00C, 8'h70, 1'b0, 1'b0, 1'b1));
    write_lr(2, mk(16'd700, 10'h004, 8'h60, 1'b1, 1'b0, 1'b1));
    eoi(16'd700, 1'b1, 1'b0, 8, 8'h60, "R13", 1'b1, 2,
        mk(16'd701, 10'h004, 8'h60, 1'b1, 1'b0, 1'b1));

    // R7: wrap of the 5-bit miss counter
    start_cnt = mcnt;
    for (int n = 0; n < 32; n++) eoi(16'd999, 1'b1, 1'b0, 8, 8'h00, "R7");
    chk("R7", "count after 32 misses", 64'(eoi_count), 64'(start_cnt));

    finish_run();
  end
endmodule